// File: doc/BRIEF.md
# Operating-Mode and Clock-Enable Controller

This block decides which power mode a small CPU subsystem is in and turns that mode into clock enables. In the two running modes, the CPU and the transfer controller share a bus-master clock enable. This enable is either asserted on every base clock (high-speed) or pulsed once every N base clocks (medium-speed, N = 2, 4, 8, 16 or 32). Peripherals get their own enable, which is asserted on every base clock whenever they are allowed to run. The block also implements sleep, software standby, hardware standby and a reset state. It reports the current mode on a one-hot status bus.

The CPU writes a 3-bit speed-select field. The new ratio does not take effect when it is written. It is copied into the active ratio on the next end-of-bus-cycle strobe, so a bus access never straddles a ratio change. A SLEEP request uses the standby-enable, low-speed and watchdog-clock-select bits to choose between sleep and software standby. Wake-up returns to the running mode with the ratio that was active before, because the active ratio is kept while the block is asleep. All inputs except `rst_n` are synchronous to `clk`. `rst_n` asserts asynchronously and is released through a two-stage synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it rises, `mode_oh` equals 6'b100000 (reset), with `bm_ce` and `per_ce` at 0. The third rising edge after release enters high-speed (`mode_oh` = 6'b000001), and the speed field is 0.
- R2: A write to the speed field (`sel_wr` with `sel_wdata`) changes nothing visible until a rising edge that samples `bus_end` high. After that edge, a nonzero field shows medium-speed (`mode_oh` = 6'b000010).
- R3: In medium-speed mode, `bm_ce` is high for one base cycle in every N. Field values 1, 2, 3, 4 and 5 give N = 2, 4, 8, 16 and 32, and the values 6 and 7 also give N = 32.
- R4: When a `bus_end` edge loads an active field value that differs from the old one, or when the block re-enters a running mode, the divider restarts. `bm_ce` then first rises in the N-th cycle after that edge.
- R5: Loading a field value of 0 at `bus_end` returns the block to high-speed, where `bm_ce` is high on every cycle.
- R6: `per_ce` is 1 in high-speed, medium-speed and sleep, and 0 in software standby, hardware standby and reset.
- R7: A `sleep_req` in a running mode with `sw_standby_en`=0 and `low_speed_en`=0 enters sleep (`mode_oh` = 6'b000100) on the next edge, and `bm_ce` is 0 during sleep.
- R8: In sleep, `irq_int` or `irq_ext` returns the block on the next edge to the speed mode and ratio it had before sleeping.
- R9: A `sleep_req` with `sw_standby_en`=1, `low_speed_en`=0 and `wdt_clk_sel`=0 enters software standby (`mode_oh` = 6'b001000). A request with `low_speed_en`=1, or with both `sw_standby_en`=1 and `wdt_clk_sel`=1, is ignored.
- R10: Software standby ends only on `irq_ext`, which returns the block to its previous speed mode. `irq_int` has no effect there.
- R11: `hw_standby_n` low enters hardware standby (`mode_oh` = 6'b010000) on the next edge from any mode. This overrides all other inputs and clears the speed field. After release, the block spends one cycle in reset and then enters high-speed.
- R12: `wdt_ovf` high in any mode other than hardware standby gives one cycle of reset, then high-speed with the speed field cleared. Its priority is below `hw_standby_n` and above wake-up.
- R13: Outside the running modes, `sleep_req`, `sel_wr` and `bus_end` have no effect on the mode or on the speed field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous assert |
| sel_wr | input | 1 | Write strobe for the speed-select field |
| sel_wdata | input | 3 | New speed-select value (0 = full rate) |
| sw_standby_en | input | 1 | Selects software standby on a SLEEP request |
| low_speed_en | input | 1 | Low-speed request bit; blocks both sleep entries when 1 |
| wdt_clk_sel | input | 1 | Watchdog prescaler select; blocks software standby when 1 |
| sleep_req | input | 1 | One-cycle SLEEP request from the CPU |
| irq_int | input | 1 | Internal interrupt (wakes from sleep only) |
| irq_ext | input | 1 | External interrupt (wakes from sleep and software standby) |
| bus_end | input | 1 | End-of-bus-cycle strobe |
| wdt_ovf | input | 1 | Watchdog overflow, forces reset |
| hw_standby_n | input | 1 | Hardware standby pin, active low |
| mode_oh | output | 6 | One-hot mode: bit0 high, bit1 medium, bit2 sleep, bit3 sw standby, bit4 hw standby, bit5 reset |
| bm_ce | output | 1 | Bus-master clock enable |
| per_ce | output | 1 | Peripheral clock enable |

## Verification
The bench loads every field value in turn and checks that the first bus-master pulse lands in the N-th cycle after the load. A design that skipped the counter restart would place that pulse anywhere in the old phase, and one that let values 6 and 7 wrap would produce a short period. Field writes made without a strobe, and writes made while asleep, are checked to leave the speed unchanged; a design that applied the ratio on the write would change speed in the middle of a bus cycle. Wake-up from sleep and from software standby is checked to restore medium speed with a fresh divider phase. Internal interrupts are checked to fail to end software standby, and the two blocked sleep-request combinations are checked to be ignored. Hardware standby and watchdog overflow are driven together with competing interrupts, so a design with the wrong priority order, or one that kept the speed field across a reset, would report the wrong mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CKS_W     = 3;
  localparam int MAX_SHIFT = 5;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int MODE_N    = 6;

  localparam int MB_HIGH  = 0;
  localparam int MB_MED   = 1;
  localparam int MB_SLEEP = 2;
  localparam int MB_SSTBY = 3;
  localparam int MB_HSTBY = 4;
  localparam int MB_RST   = 5;

  typedef enum logic [2:0] {
    ST_RST   = 3'd0,
    ST_RUN   = 3'd1,
    ST_SLEEP = 3'd2,
    ST_SSTBY = 3'd3,
    ST_HSTBY = 3'd4
  } pmc_state_e;

  // Terminal count of the bus-master divider: 2^min(sel, MAX_SHIFT) - 1
  function automatic logic [CNT_W-1:0] div_limit(input logic [CKS_W-1:0] sel);
    int unsigned sh;
    sh = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
    return CNT_W'((32'd1 << sh) - 32'd1);
  endfunction

endpackage

// File: rtl/pmc_cks_regs.sv
module pmc_cks_regs
  import pmc_pkg::*;
#(
  parameter int SEL_W = CKS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  input  logic             bus_end,
  output logic [SEL_W-1:0] act_sel,
  output logic             ratio_chg
);

  logic [SEL_W-1:0] req_q, req_d;
  logic [SEL_W-1:0] act_q, act_d;

  // Requested value follows writes; active value follows only at bus end
  always_comb begin
    req_d = req_q;
    act_d = act_q;
    if (clr) begin
      req_d = '0;
      act_d = '0;
    end else if (run) begin
      if (wr)      req_d = wdata;
      if (bus_end) act_d = req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      act_q <= '0;
    end else begin
      req_q <= req_d;
      act_q <= act_d;
    end
  end

  assign ratio_chg = run && !clr && bus_end && (req_q != act_q);
  assign act_sel   = act_q;

  assert_ratio_waits_bus_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_end && !clr) |=> $stable(act_q));

  assert_field_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (act_q == '0 && req_q == '0));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_standby_n,
  input  logic       wdt_ovf,
  input  logic       sleep_req,
  input  logic       sw_standby_en,
  input  logic       low_speed_en,
  input  logic       wdt_clk_sel,
  input  logic       irq_int,
  input  logic       irq_ext,
  output pmc_state_e state
);

  pmc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!hw_standby_n) begin
      state_d = ST_HSTBY;
    end else if (state_q == ST_HSTBY) begin
      state_d = ST_RST;
    end else if (wdt_ovf) begin
      state_d = ST_RST;
    end else begin
      unique case (state_q)
        ST_RST:   state_d = ST_RUN;
        ST_RUN: begin
          if (sleep_req && !low_speed_en) begin
            if (!sw_standby_en)   state_d = ST_SLEEP;
            else if (!wdt_clk_sel) state_d = ST_SSTBY;
          end
        end
        ST_SLEEP: if (irq_int || irq_ext) state_d = ST_RUN;
        ST_SSTBY: if (irq_ext)            state_d = ST_RUN;
        default:  state_d = ST_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RST;
    else        state_q <= state_d;
  end

  assign state = state_q;

  assert_hw_standby_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_standby_n |=> (state_q == ST_HSTBY));

  assert_wdt_resets_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_standby_n && wdt_ovf) |=> (state_q == ST_RST));

  assert_sstby_needs_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SSTBY && !irq_ext && hw_standby_n && !wdt_ovf) |=> (state_q == ST_SSTBY));

  assert_sleep_ignores_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !irq_int && !irq_ext && hw_standby_n && !wdt_ovf) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div
  import pmc_pkg::*;
#(
  parameter int DW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [DW-1:0] lim,
  output logic          ce
);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || restart)   cnt_d = '0;
    else if (cnt_q == lim) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ce = run && (cnt_q == lim);

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && lim != '0 && !restart) |=> !ce);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [CKS_W-1:0]  sel_wdata,
  input  logic              sw_standby_en,
  input  logic              low_speed_en,
  input  logic              wdt_clk_sel,
  input  logic              sleep_req,
  input  logic              irq_int,
  input  logic              irq_ext,
  input  logic              bus_end,
  input  logic              wdt_ovf,
  input  logic              hw_standby_n,
  output logic [MODE_N-1:0] mode_oh,
  output logic              bm_ce,
  output logic              per_ce
);

  logic [1:0]       sync_q;
  logic             rst_int_n;
  pmc_state_e       state;
  logic             run, clr, ratio_chg;
  logic [CKS_W-1:0] act_sel;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  pmc_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .hw_standby_n  (hw_standby_n),
    .wdt_ovf       (wdt_ovf),
    .sleep_req     (sleep_req),
    .sw_standby_en (sw_standby_en),
    .low_speed_en  (low_speed_en),
    .wdt_clk_sel   (wdt_clk_sel),
    .irq_int       (irq_int),
    .irq_ext       (irq_ext),
    .state         (state)
  );

  assign run = (state == ST_RUN);
  assign clr = (state == ST_RST) || (state == ST_HSTBY);

  pmc_cks_regs #(.SEL_W(CKS_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .run       (run),
    .wr        (sel_wr),
    .wdata     (sel_wdata),
    .bus_end   (bus_end),
    .act_sel   (act_sel),
    .ratio_chg (ratio_chg)
  );

  pmc_clk_div #(.DW(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .restart (ratio_chg),
    .lim     (div_limit(act_sel)),
    .ce      (bm_ce)
  );

  assign per_ce = (state == ST_RUN) || (state == ST_SLEEP);

  always_comb begin
    mode_oh           = '0;
    mode_oh[MB_HIGH]  = run && (act_sel == '0);
    mode_oh[MB_MED]   = run && (act_sel != '0);
    mode_oh[MB_SLEEP] = (state == ST_SLEEP);
    mode_oh[MB_SSTBY] = (state == ST_SSTBY);
    mode_oh[MB_HSTBY] = (state == ST_HSTBY);
    mode_oh[MB_RST]   = (state == ST_RST);
  end

  assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(mode_oh) == 1);

  assert_standby_stops_bm_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !per_ce |-> !bm_ce);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n, sel_wr, sw_standby_en, low_speed_en, wdt_clk_sel;
  logic       sleep_req, irq_int, irq_ext, bus_end, wdt_ovf, hw_standby_n;
  logic [2:0] sel_wdata;
  logic [5:0] mode_oh;
  logic       bm_ce, per_ce;

  int nchk = 0, nfail = 0;
  bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sw_standby_en(sw_standby_en), .low_speed_en(low_speed_en),
    .wdt_clk_sel(wdt_clk_sel), .sleep_req(sleep_req), .irq_int(irq_int),
    .irq_ext(irq_ext), .bus_end(bus_end), .wdt_ovf(wdt_ovf),
    .hw_standby_n(hw_standby_n), .mode_oh(mode_oh), .bm_ce(bm_ce), .per_ce(per_ce)
  );

  // Behavioural reference: 0 reset, 1 running, 2 sleep, 3 sw standby, 4 hw standby
  int m_st, m_req, m_act, m_cnt, m_sync;

  function automatic int period(input int sel);
    return 1 << ((sel > 5) ? 5 : sel);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_req = 0; m_act = 0; m_cnt = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int ns, nreq, nact, ncnt;
      ns = m_st; nreq = m_req; nact = m_act;
      if (!hw_standby_n) ns = 4;
      else if (m_st == 4) ns = 0;
      else if (wdt_ovf) ns = 0;
      else if (m_st == 0) ns = 1;
      else if (m_st == 1 && sleep_req && !low_speed_en) begin
        if (!sw_standby_en) ns = 2;
        else if (!wdt_clk_sel) ns = 3;
      end else if (m_st == 2 && (irq_int || irq_ext)) ns = 1;
      else if (m_st == 3 && irq_ext) ns = 1;
      if (m_st == 0 || m_st == 4) begin
        nreq = 0; nact = 0;
      end else if (m_st == 1) begin
        if (sel_wr) nreq = sel_wdata;
        if (bus_end) nact = m_req;
      end
      if (m_st != 1 || (bus_end && m_req != m_act)) ncnt = 0;
      else if (m_cnt == period(m_act) - 1) ncnt = 0;
      else ncnt = m_cnt + 1;
      m_st = ns; m_req = nreq; m_act = nact; m_cnt = ncnt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, a, e, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int eoh, ebm, epr;
      string tg;
      case (m_st)
        0: begin eoh = 32; tg = "R1"; end
        1: begin eoh = (m_act == 0) ? 1 : 2; tg = (m_act == 0) ? "R5" : "R2"; end
        2: begin eoh = 4; tg = "R7"; end
        3: begin eoh = 8; tg = "R9"; end
        default: begin eoh = 16; tg = "R11"; end
      endcase
      ebm = (m_st == 1 && (m_act == 0 || m_cnt == period(m_act) - 1)) ? 1 : 0;
      epr = (m_st == 1 || m_st == 2) ? 1 : 0;
      chk(int'(mode_oh) == eoh, {tg, " model mode"}, mode_oh, eoh);
      chk(int'(bm_ce) == ebm, "R3 model bm_ce", bm_ce, ebm);
      chk(int'(per_ce) == epr, "R6 model per_ce", per_ce, epr);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_mode(input int e, input string tag);
    chk(int'(mode_oh) == e, tag, mode_oh, e);
  endtask

  task automatic load_sel(input int v);
    sel_wr = 1; sel_wdata = 3'(v); tick(); sel_wr = 0;
    bus_end = 1; tick(); bus_end = 0;
  endtask

  task automatic expect_period(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      chk(int'(bm_ce) == ((i == n) ? 1 : 0), tag, bm_ce, (i == n) ? 1 : 0);
      if (i < n) tick();
    end
  endtask

  task automatic req_sleep();
    sleep_req = 1; tick(); sleep_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel_wr = 0; sel_wdata = 0; sw_standby_en = 0; low_speed_en = 0;
    wdt_clk_sel = 0; sleep_req = 0; irq_int = 0; irq_ext = 0; bus_end = 0;
    wdt_ovf = 0; hw_standby_n = 1;
    repeat (3) tick();
    cmp_on = 1;
    chk_mode(32, "R1 reset held");
    chk(per_ce == 0 && bm_ce == 0, "R1 enables off in reset", per_ce, 0);
    rst_n = 1; tick();
    chk_mode(32, "R1 reset during sync");
    tick(); tick();
    chk_mode(1, "R1 high-speed after release");

    // R2: write alone does nothing
    sel_wr = 1; sel_wdata = 3'd2; tick(); sel_wr = 0;
    repeat (4) tick();
    chk_mode(1, "R2 no change before bus_end");
    bus_end = 1; tick(); bus_end = 0;
    chk_mode(2, "R2 medium after bus_end");
    expect_period(4, "R4 first pulse after load /4");

    // R3/R4: every field value
    for (int c = 1; c <= 7; c++) begin
      load_sel(c);
      expect_period(period(c), "R4 restart phase");
      tick();
      expect_period(period(c), "R3 steady period");
    end

    // R5
    load_sel(0);
    chk_mode(1, "R5 back to high-speed");
    for (int i = 0; i < 3; i++) begin chk(bm_ce == 1, "R5 full-rate bm_ce", bm_ce, 1); tick(); end

    // R7/R8
    load_sel(3);
    req_sleep();
    chk_mode(4, "R7 sleep entered");
    chk(bm_ce == 0 && per_ce == 1, "R7 bm off per on", {bm_ce, per_ce}, 1);
    // R13: activity while asleep is ignored
    sel_wr = 1; sel_wdata = 0; bus_end = 1; sleep_req = 1; tick();
    sel_wr = 0; bus_end = 0; sleep_req = 0;
    chk_mode(4, "R13 sleep ignores inputs");
    repeat (3) tick();
    irq_int = 1; tick(); irq_int = 0;
    chk_mode(2, "R8 wake to medium");
    expect_period(8, "R4 first pulse after wake");
    bus_end = 1; tick(); bus_end = 0;
    chk_mode(2, "R13 field unchanged by write in sleep");

    // R9
    sw_standby_en = 1; low_speed_en = 1; req_sleep();
    chk_mode(2, "R9 low-speed blocks entry");
    low_speed_en = 0; wdt_clk_sel = 1; req_sleep();
    chk_mode(2, "R9 watchdog select blocks standby");
    wdt_clk_sel = 0; req_sleep();
    chk_mode(8, "R9 sw standby entered");
    chk(per_ce == 0, "R6 per_ce off in sw standby", per_ce, 0);

    // R10
    irq_int = 1; tick(); irq_int = 0;
    chk_mode(8, "R10 internal irq ignored");
    irq_ext = 1; tick(); irq_ext = 0;
    chk_mode(2, "R10 external irq wakes to medium");
    expect_period(8, "R4 pulse after standby wake");
    sw_standby_en = 0;

    // R12
    wdt_ovf = 1; irq_int = 1; tick(); wdt_ovf = 0; irq_int = 0;
    chk_mode(32, "R12 watchdog reset");
    tick();
    chk_mode(1, "R12 high-speed after reset");
    bus_end = 1; tick(); bus_end = 0;
    chk_mode(1, "R12 field cleared");

    // R11
    load_sel(4);
    req_sleep();
    hw_standby_n = 0; irq_int = 1; wdt_ovf = 1; tick();
    irq_int = 0; wdt_ovf = 0;
    chk_mode(16, "R11 hw standby from sleep");
    chk(per_ce == 0 && bm_ce == 0, "R11 enables off", per_ce, 0);
    irq_ext = 1; tick(); irq_ext = 0;
    chk_mode(16, "R11 hw standby holds");
    hw_standby_n = 1; tick();
    chk_mode(32, "R11 reset after release");
    tick();
    chk_mode(1, "R11 high-speed, field cleared");
    repeat (4) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule